// File: doc/BRIEF.md
# Block-Lock Write Protection Gate

This block sits between a serial-bus command decoder and a 16K x 8 nonvolatile memory. Each byte the decoder wants to store arrives as a request. The request names its target, which is either the memory array or the block's own 8-bit control register. The block decides whether the byte may be written. An array byte that is allowed is passed on as a one-cycle memory write strobe, with its address and data. A byte that is refused produces a one-cycle reject pulse, and nothing is changed.

The control register holds the protection setting. A family bit selects one of two families of protected region. The fractional family covers a quarter, a half or the whole array. The byte-count family covers a block of 64, 128, 256 or 512 bytes. A protected region always ends at the highest address. A lock-enable bit in the same register works together with the external write-protect pin to freeze the register.

Multi-byte page writes are supported. Only the first byte of a burst carries an address. Each later byte goes to the next location in the same 64-byte page, wrapping at the page end. Every byte is checked against the protected range on its own.

Top module: `blk_lock_wprot`

## Requirements
- R1: After reset, `ctrl_reg` is 0x00 and `mem_we` and `wr_reject` are low.
- R2: With `ctrl_reg[3]`=0 (fractional family), `ctrl_reg[2:0]` selects the protected region. Code 1 protects the top quarter (addresses 0x3000 and up). Code 2 protects the top half (0x2000 and up). Code 3 protects the whole array. Codes 0 and 4 to 7 protect nothing.
- R3: With `ctrl_reg[3]`=1 (byte-count family), codes 0, 1, 2 and 3 protect the top 64, 128, 256 and 512 bytes respectively. Codes 4 to 7 protect nothing.
- R4: An allowed array byte gives `mem_we` high for exactly the cycle after the request. In that cycle `mem_addr` holds the byte's address and `mem_data` holds its data.
- R5: A refused array byte gives no `mem_we`. It gives `wr_reject` high for exactly the following cycle, and `mem_we` and `wr_reject` are never high together.
- R6: A control-register write while `wp_pin`=1 and `ctrl_reg[7]`=1 is refused. `ctrl_reg` keeps its value and `wr_reject` pulses.
- R7: A control-register write while `wp_pin`=0 or `ctrl_reg[7]`=0 is stored on the next edge, whatever the array protection is. Only bits 7 and 3:0 are kept, and bits 6:4 always read zero.
- R8: A byte with `req_first`=0 goes to the previous array byte's address plus one in its low 6 bits. It wraps within the 64-byte page, and the upper address bits are held.
- R9: The burst address advances on every array byte, whether it was refused or allowed. Control-register writes do not move it.
- R10: A control-register write never raises `mem_we`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | One byte write request this cycle |
| req_target | input | 1 | 0 = memory array, 1 = control register |
| req_first | input | 1 | First byte of a burst; use `req_addr` |
| req_addr | input | 14 | Byte address (read only when `req_first`=1) |
| req_data | input | 8 | Byte to write |
| wp_pin | input | 1 | External write-protect level |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | 14 | Array write address |
| mem_data | output | 8 | Array write data |
| wr_reject | output | 1 | One-cycle pulse for a refused byte |
| ctrl_reg | output | 8 | Control register: [7] lock enable, [3] family, [2:0] code |

## Verification
The bench uses the default parameters: a 14-bit address and 6-bit page offset. With these values every boundary of both region families is a fixed, checkable address. The bench probes the addresses one below and at each boundary, from 0x1FFF/0x2000 up to 0x3FBF/0x3FC0. The page of 64 bytes also makes the wrap from 0x3F7F to 0x3F40 reachable in three bytes. A protected page at the top of the array shows that the burst address advances across refused bytes.

// File: rtl/blk_lock_pkg.sv
package blk_lock_pkg;

    typedef enum logic {
        TGT_ARRAY = 1'b0,
        TGT_CTRL  = 1'b1
    } tgt_e;

    typedef struct packed {
        logic       lock_en;
        logic       family;   // 0: fractional, 1: byte count
        logic [2:0] code;
    } prot_cfg_t;

    localparam logic [7:0] CTRL_KEEP = 8'h8F;

    function automatic prot_cfg_t cfg_of(input logic [7:0] r);
        prot_cfg_t c;
        c.lock_en = r[7];
        c.family  = r[3];
        c.code    = r[2:0];
        return c;
    endfunction

endpackage

// File: rtl/blk_lock_region.sv
module blk_lock_region
    import blk_lock_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int PAGE_W = 6
) (
    input  prot_cfg_t          cfg,
    output logic               prot_en,
    output logic [ADDR_W-1:0]  prot_base
);
    localparam logic [ADDR_W:0] DEPTH = (ADDR_W+1)'(1) << ADDR_W;
    localparam logic [ADDR_W:0] PAGE  = (ADDR_W+1)'(1) << PAGE_W;

    logic [ADDR_W:0] size;
    logic [ADDR_W:0] base_w;

    always_comb begin
        size    = '0;
        prot_en = 1'b0;
        if (!cfg.code[2]) begin
            if (cfg.family) begin
                prot_en = 1'b1;
                size    = PAGE << cfg.code[1:0];
            end else begin
                unique case (cfg.code[1:0])
                    2'd1:    begin prot_en = 1'b1; size = DEPTH >> 2; end
                    2'd2:    begin prot_en = 1'b1; size = DEPTH >> 1; end
                    2'd3:    begin prot_en = 1'b1; size = DEPTH;      end
                    default: begin prot_en = 1'b0; size = '0;         end
                endcase
            end
        end
        base_w    = DEPTH - size;
        prot_base = base_w[ADDR_W-1:0];
    end

endmodule

// File: rtl/blk_lock_page.sv
module blk_lock_page #(
    parameter int ADDR_W = 14,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              step,
    input  logic              first,
    input  logic [ADDR_W-1:0] start_addr,
    output logic [ADDR_W-1:0] eff_addr
);
    logic [ADDR_W-1:0] ptr_q;
    logic [PAGE_W-1:0] low_nxt;

    assign eff_addr = first ? start_addr : ptr_q;
    assign low_nxt  = eff_addr[PAGE_W-1:0] + PAGE_W'(1);

    always_ff @(posedge clk) begin
        if (rst) begin
            ptr_q <= '0;
        end else if (step) begin
            ptr_q <= {eff_addr[ADDR_W-1:PAGE_W], low_nxt};
        end
    end

endmodule

// File: rtl/blk_lock_wprot.sv
module blk_lock_wprot
    import blk_lock_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8,
    parameter int PAGE_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_target,
    input  logic              req_first,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              wp_pin,
    output logic              mem_we,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [DATA_W-1:0] mem_data,
    output logic              wr_reject,
    output logic [7:0]        ctrl_reg
);
    prot_cfg_t         cfg;
    logic              prot_en;
    logic [ADDR_W-1:0] prot_base;
    logic [ADDR_W-1:0] eff_addr;
    logic              is_arr;
    logic              is_ctl;
    logic              arr_ok;
    logic              ctl_ok;
    logic [7:0]        ctrl_q;

    assign cfg    = cfg_of(ctrl_q);
    assign is_arr = req_valid && (tgt_e'(req_target) == TGT_ARRAY);
    assign is_ctl = req_valid && (tgt_e'(req_target) == TGT_CTRL);

    blk_lock_region #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_region (
        .cfg       (cfg),
        .prot_en   (prot_en),
        .prot_base (prot_base)
    );

    blk_lock_page #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_page (
        .clk        (clk),
        .rst        (rst),
        .step       (is_arr),
        .first      (req_first),
        .start_addr (req_addr),
        .eff_addr   (eff_addr)
    );

    assign arr_ok = !(prot_en && (eff_addr >= prot_base));
    assign ctl_ok = !(wp_pin && cfg.lock_en);

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q    <= '0;
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_data  <= '0;
            wr_reject <= 1'b0;
        end else begin
            mem_we    <= is_arr && arr_ok;
            wr_reject <= (is_arr && !arr_ok) || (is_ctl && !ctl_ok);
            if (is_arr) begin
                mem_addr <= eff_addr;
                mem_data <= req_data;
            end
            if (is_ctl && ctl_ok) begin
                ctrl_q <= req_data[7:0] & CTRL_KEEP;
            end
        end
    end

    assign ctrl_reg = ctrl_q;

endmodule

// File: rtl/blk_lock_wprot_chk.sv
module blk_lock_wprot_chk #(
    parameter int ADDR_W = 14,
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_target,
    input logic [DATA_W-1:0] req_data,
    input logic              wp_pin,
    input logic              mem_we,
    input logic              wr_reject,
    input logic [7:0]        ctrl_reg
);
    assert_we_rej_excl_R5: assert property (@(posedge clk) disable iff (rst)
        !(mem_we && wr_reject));

    assert_ctrl_locked_R6: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_target && wp_pin && ctrl_reg[7])
        |=> (wr_reject && $stable(ctrl_reg)));

    assert_ctrl_open_R7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_target && !(wp_pin && ctrl_reg[7]))
        |=> (!wr_reject && ctrl_reg[6:4] == 3'b000
             && ctrl_reg[3:0] == $past(req_data[3:0])));

    assert_ctrl_no_we_R10: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_target) |=> !mem_we);

    assert_we_needs_req_R4: assert property (@(posedge clk) disable iff (rst)
        mem_we |-> $past(req_valid && !req_target));

    assert_whole_locked_R2: assert property (@(posedge clk) disable iff (rst)
        (req_valid && !req_target && ctrl_reg[3:0] == 4'h3) |=> (!mem_we && wr_reject));

endmodule

bind blk_lock_wprot blk_lock_wprot_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_target (req_target),
    .req_data   (req_data),
    .wp_pin     (wp_pin),
    .mem_we     (mem_we),
    .wr_reject  (wr_reject),
    .ctrl_reg   (ctrl_reg)
);

// File: tb/test_blk_lock_wprot.sv
module test_blk_lock_wprot;

    logic        clk = 1'b0;
    logic        rst;
    logic        req_valid, req_target, req_first, wp_pin;
    logic [13:0] req_addr;
    logic [7:0]  req_data;
    logic        mem_we, wr_reject;
    logic [13:0] mem_addr;
    logic [7:0]  mem_data, ctrl_reg;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #10 clk = ~clk;

    blk_lock_wprot i_blk_lock_wprot (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_target(req_target),
        .req_first(req_first), .req_addr(req_addr), .req_data(req_data),
        .wp_pin(wp_pin), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_data(mem_data), .wr_reject(wr_reject), .ctrl_reg(ctrl_reg)
    );

    typedef struct packed {
        logic        tgt;
        logic        first;
        logic        wp;
        logic [13:0] addr;
        logic [7:0]  data;
        logic        we;
        logic        rej;
        logic [13:0] xaddr;
        logic [7:0]  xctrl;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 39;
    localparam vec_t VEC [NV] = '{
        '{1,1,0,14'h0000,8'h01,0,0,14'h0000,8'h01,8'd7},  // R7 quarter
        '{0,1,0,14'h2FFF,8'hA1,1,0,14'h2FFF,8'h01,8'd2},  // R2
        '{0,1,0,14'h3000,8'hA2,0,1,14'h0000,8'h01,8'd2},  // R2
        '{1,1,0,14'h0000,8'h02,0,0,14'h0000,8'h02,8'd7},
        '{0,1,0,14'h2000,8'hA3,0,1,14'h0000,8'h02,8'd2},
        '{0,1,0,14'h1FFF,8'hA4,1,0,14'h1FFF,8'h02,8'd2},
        '{1,1,0,14'h0000,8'h03,0,0,14'h0000,8'h03,8'd7},
        '{0,1,0,14'h0000,8'hA5,0,1,14'h0000,8'h03,8'd2},  // R2 whole
        '{1,1,0,14'h0000,8'h04,0,0,14'h0000,8'h04,8'd7},
        '{0,1,0,14'h3FFF,8'hA6,1,0,14'h3FFF,8'h04,8'd2},  // R2 code 4
        '{1,1,0,14'h0000,8'h08,0,0,14'h0000,8'h08,8'd7},
        '{0,1,0,14'h3FC0,8'hB1,0,1,14'h0000,8'h08,8'd3},  // R3 64
        '{0,1,0,14'h3FBF,8'hB2,1,0,14'h3FBF,8'h08,8'd3},
        '{1,1,0,14'h0000,8'h09,0,0,14'h0000,8'h09,8'd7},
        '{0,1,0,14'h3F80,8'hB3,0,1,14'h0000,8'h09,8'd3},  // R3 128
        '{0,1,0,14'h3F7F,8'hB4,1,0,14'h3F7F,8'h09,8'd3},
        '{1,1,0,14'h0000,8'h0A,0,0,14'h0000,8'h0A,8'd7},
        '{0,1,0,14'h3F00,8'hB5,0,1,14'h0000,8'h0A,8'd3},  // R3 256
        '{0,1,0,14'h3EFF,8'hB6,1,0,14'h3EFF,8'h0A,8'd3},
        '{1,1,0,14'h0000,8'h0B,0,0,14'h0000,8'h0B,8'd7},
        '{0,1,0,14'h3E00,8'hB7,0,1,14'h0000,8'h0B,8'd3},  // R3 512
        '{0,1,0,14'h3DFF,8'hB8,1,0,14'h3DFF,8'h0B,8'd3},
        '{1,1,0,14'h0000,8'h0C,0,0,14'h0000,8'h0C,8'd7},
        '{0,1,0,14'h3FFF,8'hB9,1,0,14'h3FFF,8'h0C,8'd3},  // R3 code 4
        '{1,1,0,14'h0000,8'h08,0,0,14'h0000,8'h08,8'd7},
        '{0,1,0,14'h3F7E,8'hC1,1,0,14'h3F7E,8'h08,8'd4},  // R4 page start
        '{0,0,0,14'h0000,8'hC2,1,0,14'h3F7F,8'h08,8'd8},  // R8
        '{0,0,0,14'h0000,8'hC3,1,0,14'h3F40,8'h08,8'd8},  // R8 wrap
        '{0,1,0,14'h3FFE,8'hC4,0,1,14'h0000,8'h08,8'd5},  // R5
        '{0,0,0,14'h0000,8'hC5,0,1,14'h0000,8'h08,8'd9},  // R9 (0x3FFF)
        '{1,1,0,14'h0000,8'h00,0,0,14'h0000,8'h00,8'd10}, // R10
        '{0,0,0,14'h0000,8'hC6,1,0,14'h3FC0,8'h00,8'd9},  // R9 advanced
        '{1,1,1,14'h0000,8'h80,0,0,14'h0000,8'h80,8'd7},  // R7 wp, unlocked
        '{1,1,1,14'h0000,8'h03,0,1,14'h0000,8'h80,8'd6},  // R6
        '{1,1,0,14'h0000,8'h03,0,0,14'h0000,8'h03,8'd7},  // R7 wp low
        '{0,1,0,14'h0100,8'hD1,0,1,14'h0000,8'h03,8'd2},
        '{1,1,1,14'h0000,8'hF8,0,0,14'h0000,8'h88,8'd7},  // R7 mask
        '{1,1,1,14'h0000,8'h00,0,1,14'h0000,8'h88,8'd6},  // R6
        '{0,1,1,14'h3FFF,8'hD2,0,1,14'h0000,8'h88,8'd3}
    };

    task automatic chk(input string what, input int req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL R%0d %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        req_valid = 0; req_target = 0; req_first = 0;
        req_addr = '0; req_data = '0;
    endtask

    initial begin
        while (cycles < 100000) begin
            @(posedge clk);
            cycles++;
        end
        errors++;
        $display("FAIL R1 watchdog: actual %0d expected 0", cycles);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        wp_pin = 0;
        rst = 1;
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R1 reset state
        chk("reset ctrl", 1, ctrl_reg, 0);
        chk("reset we", 1, mem_we, 0);
        chk("reset rej", 1, wr_reject, 0);

        for (int i = 0; i < NV; i++) begin
            req_valid  = 1;
            req_target = VEC[i].tgt;
            req_first  = VEC[i].first;
            wp_pin     = VEC[i].wp;
            req_addr   = VEC[i].addr;
            req_data   = VEC[i].data;
            @(negedge clk);
            chk($sformatf("vec %0d we", i), VEC[i].req, mem_we, VEC[i].we);
            chk($sformatf("vec %0d rej", i), VEC[i].req, wr_reject, VEC[i].rej);
            chk($sformatf("vec %0d ctrl", i), VEC[i].req, ctrl_reg, VEC[i].xctrl);
            if (VEC[i].we) begin
                chk($sformatf("vec %0d addr", i), VEC[i].req, mem_addr, VEC[i].xaddr);
                chk($sformatf("vec %0d data", i), VEC[i].req, mem_data, VEC[i].data);
            end
        end

        // R5: reject is a single-cycle pulse
        idle();
        @(negedge clk);
        chk("reject pulse ends", 5, wr_reject, 0);
        // R4: write strobe is a single-cycle pulse
        wp_pin = 0;
        req_valid = 1; req_target = 1; req_first = 1; req_data = 8'h00;
        @(negedge clk);
        req_target = 0; req_addr = 14'h0123; req_data = 8'h77;
        @(negedge clk);
        chk("we one", 4, mem_we, 1);
        chk("we addr", 4, mem_addr, 14'h0123);
        idle();
        @(negedge clk);
        chk("we pulse ends", 4, mem_we, 0);
        // R1: reset mid-run clears the control register
        req_valid = 1; req_target = 1; req_first = 1; req_data = 8'h8B;
        @(negedge clk);
        idle();
        chk("ctrl before reset", 7, ctrl_reg, 8'h8B);
        rst = 1;
        @(negedge clk);
        rst = 0;
        chk("reset clears ctrl", 1, ctrl_reg, 0);
        @(negedge clk);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule